// File: doc/BRIEF.md
# Multichannel HDLC Address Field Filter

This block decides, for each of up to 32 receive channels, whether an incoming HDLC frame is kept or dropped according to its two address octets. Each channel owns a 16-bit expected address word and a 16-bit don't-care mask word. Two configuration vectors give every channel its own compare enable for the first octet and for the second. The receive datapath presents the first and then the second octet after the opening flag, tagged with the channel number. One cycle after the octet that settles the outcome, the block pulses a decision carrying the channel and an accept flag.

A microprocessor never addresses the two memories directly. It first writes a 16-bit data register and then writes a command register that names a channel, a direction and a target memory. Writing the command register launches the access. A read command returns the selected word in the data register. Receive lookups own the memories: a pending processor access waits for the first cycle with no receive octet.

Top module: `hdlc_afr_top`

## Requirements
- R1: After reset the command register, the data register, `cpu_busy` and `dec_valid` are all 0, and every address and mask word reads back as 0000h.
- R2: A command write stores bits [4:0] as the channel, bit 5 as the direction (1 = read, 0 = write) and bit 6 as the target (1 = mask memory, 0 = address memory). Bits 15:7 are stored as 0, and `cpu_cmd_q` shows the stored value.
- R3: A memory access starts only from a command write. A write to the data register alone changes no memory word. `cpu_busy` is high in the cycle after an accepted command write.
- R4: A pending access executes at the first clock edge where `rx_valid` is low. A write copies the data register into the selected word. A read loads the selected word into the data register, and this load takes priority over a data register write in the same cycle.
- R5: Bits 7:0 of a stored word apply to the first address octet and bits 15:8 apply to the second.
- R6: A mask bit of 1 removes the matching octet bit from the comparison. A mask bit of 0 requires the received bit to equal the stored address bit.
- R7: A channel's first octet is compared only when its `cfg_en_first` bit is set, and its second octet only when its `cfg_en_second` bit is set. The decision pulse appears in the cycle after the second octet when the second enable is set. Otherwise it appears in the cycle after the first octet.
- R8: When both enables of a channel are clear, the first octet yields an accept decision in the next cycle.
- R9: A difference in any compared bit of either octet makes the decision a reject.
- R10: While an access is pending and `rx_valid` is high, the access is not executed and `cpu_busy` stays high.
- R11: A command write made while `cpu_busy` is high is dropped, and the command register keeps its value.
- R12: A second octet on a channel whose `cfg_en_second` bit is clear produces no decision pulse. A first octet on a channel whose `cfg_en_second` bit is set produces none either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_cmd_we | input | 1 | Command register write strobe |
| cpu_cmd_wdata | input | 16 | Command word |
| cpu_data_we | input | 1 | Data register write strobe |
| cpu_data_wdata | input | 16 | Data word |
| cpu_cmd_q | output | 16 | Command register contents |
| cpu_data_q | output | 16 | Data register contents |
| cpu_busy | output | 1 | A command is pending |
| rx_valid | input | 1 | Receive octet present |
| rx_ch | input | 5 | Receive channel |
| rx_second | input | 1 | 1 = second address octet, 0 = first |
| rx_byte | input | 8 | Received octet |
| cfg_en_first | input | 32 | Per-channel first-octet compare enable |
| cfg_en_second | input | 32 | Per-channel second-octet compare enable |
| dec_valid | output | 1 | Decision pulse |
| dec_ch | output | 5 | Channel of the decision |
| dec_accept | output | 1 | 1 = frame kept, 0 = frame dropped |

## Verification
Register writes appear on `cpu_cmd_q` and `cpu_data_q` one edge after the strobe. `cpu_busy` rises at that same edge. A read result lands at the first later edge whose cycle has `rx_valid` low. The decision outputs follow the settling octet by exactly one edge. The bench drives every input just after a falling edge and updates its reference model at the rising edge. It compares all outputs at the next falling edge, so each result is checked in the single cycle where it is due, and a missing or extra decision pulse is reported.

// File: rtl/hdlc_afr_pkg.sv
package hdlc_afr_pkg;

   localparam int unsigned OCTET_W = 8;

   typedef enum logic {
      TGT_ADDR = 1'b0,
      TGT_MASK = 1'b1
   } afr_tgt_e;

   // True when every bit not excluded by the mask agrees with the stored value
   function automatic logic octet_match(input logic [OCTET_W-1:0] rx,
                                        input logic [OCTET_W-1:0] ref_v,
                                        input logic [OCTET_W-1:0] dontcare);
      return ((rx ^ ref_v) & ~dontcare) == '0;
   endfunction

endpackage

// File: rtl/afr_regfile.sv
module afr_regfile
   import hdlc_afr_pkg::*;
#(
   parameter int unsigned NUM_CH   = 32,
   parameter int unsigned WORD_W   = 16,
   parameter bit          HAS_MASK = 1'b1,
   localparam int unsigned CH_W    = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  afr_tgt_e          acc_tgt,
   input  logic [CH_W-1:0]   acc_ch,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] acc_rdata,
   input  logic [CH_W-1:0]   rx_ch,
   output logic [WORD_W-1:0] rx_addr,
   output logic [WORD_W-1:0] rx_mask
);

   logic [WORD_W-1:0] addr_rd [NUM_CH];
   logic [WORD_W-1:0] mask_rd [NUM_CH];

   for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic sel_here;
      logic [WORD_W-1:0] addr_q;
      assign sel_here = wr_en && (acc_ch == CH_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr_q <= '0;
         else if (sel_here && acc_tgt == TGT_ADDR)
            addr_q <= wr_data;
      end
      assign addr_rd[gi] = addr_q;

      if (HAS_MASK) begin : g_mask
         logic [WORD_W-1:0] mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_q <= '0;
            else if (sel_here && acc_tgt == TGT_MASK)
               mask_q <= wr_data;
         end
         assign mask_rd[gi] = mask_q;
      end else begin : g_nomask
         assign mask_rd[gi] = '0;
      end
   end

   assign acc_rdata = (acc_tgt == TGT_MASK) ? mask_rd[acc_ch] : addr_rd[acc_ch];
   assign rx_addr   = addr_rd[rx_ch];
   assign rx_mask   = mask_rd[rx_ch];

endmodule

// File: rtl/afr_cpu_port.sv
module afr_cpu_port
   import hdlc_afr_pkg::*;
#(
   parameter int unsigned CH_W   = 5,
   parameter int unsigned CMD_W  = 16,
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic              data_we,
   input  logic [WORD_W-1:0] data_wdata,
   input  logic              rx_lookup,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [CMD_W-1:0]  cmd_q,
   output logic [WORD_W-1:0] data_q,
   output logic              busy,
   output logic [CH_W-1:0]   acc_ch,
   output afr_tgt_e          acc_tgt,
   output logic              mem_we
);

   localparam int unsigned DIR_BIT = CH_W;
   localparam int unsigned TGT_BIT = CH_W + 1;
   localparam int unsigned USED_W  = CH_W + 2;
   localparam logic [CMD_W-1:0] CMD_KEEP = {{(CMD_W-USED_W){1'b0}}, {USED_W{1'b1}}};

   if (CMD_W < USED_W) begin : g_bad_cmd_w
      $error("afr_cpu_port: command register too narrow for channel field");
   end

   logic pend_q;
   logic exec;

   assign exec = pend_q && !rx_lookup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         pend_q <= 1'b0;
      end else if (cmd_we && !pend_q) begin
         cmd_q  <= cmd_wdata & CMD_KEEP;
         pend_q <= 1'b1;
      end else if (exec) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (exec && cmd_q[DIR_BIT])
         data_q <= mem_rdata;
      else if (data_we)
         data_q <= data_wdata;
   end

   assign busy    = pend_q;
   assign acc_ch  = cmd_q[CH_W-1:0];
   assign acc_tgt = afr_tgt_e'(cmd_q[TGT_BIT]);
   assign mem_we  = exec && !cmd_q[DIR_BIT];

   assert_busy_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !busy) |=> busy);
   assert_rx_holds_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rx_lookup) |=> busy);
   assert_idle_runs_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rx_lookup) |=> !busy);
   assert_cmd_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_q));

endmodule

// File: rtl/afr_match.sv
module afr_match
   import hdlc_afr_pkg::*;
#(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_valid,
   input  logic [CH_W-1:0]     rx_ch,
   input  logic                rx_second,
   input  logic [OCTET_W-1:0]  rx_byte,
   input  logic [WORD_W-1:0]   ref_word,
   input  logic [WORD_W-1:0]   dc_word,
   input  logic [NUM_CH-1:0]   en_first,
   input  logic [NUM_CH-1:0]   en_second,
   output logic                dec_valid,
   output logic [CH_W-1:0]     dec_ch,
   output logic                dec_accept
);

   logic [NUM_CH-1:0]  first_ok_q;
   logic [OCTET_W-1:0] ref_oct, dc_oct;
   logic               hit, en1, en2, fire, verdict, park;

   always_comb begin
      ref_oct = rx_second ? ref_word[2*OCTET_W-1:OCTET_W] : ref_word[OCTET_W-1:0];
      dc_oct  = rx_second ? dc_word[2*OCTET_W-1:OCTET_W]  : dc_word[OCTET_W-1:0];
      hit     = octet_match(rx_byte, ref_oct, dc_oct);
      en1     = en_first[rx_ch];
      en2     = en_second[rx_ch];
      fire    = 1'b0;
      park    = 1'b0;
      verdict = 1'b0;
      if (rx_valid) begin
         if (!rx_second) begin
            if (en2) park = 1'b1;
            else begin
               fire    = 1'b1;
               verdict = !en1 || hit;
            end
         end else if (en2) begin
            fire    = 1'b1;
            verdict = first_ok_q[rx_ch] && hit;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_ok_q <= '0;
         dec_valid  <= 1'b0;
         dec_ch     <= '0;
         dec_accept <= 1'b0;
      end else begin
         if (park) first_ok_q[rx_ch] <= !en1 || hit;
         dec_valid <= fire;
         if (fire) begin
            dec_ch     <= rx_ch;
            dec_accept <= verdict;
         end
      end
   end

   assert_no_pulse_without_octet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !dec_valid);
   assert_open_channel_accepts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_second && !en_first[rx_ch] && !en_second[rx_ch])
      |=> (dec_valid && dec_accept));
   assert_unused_second_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_second && !en_second[rx_ch]) |=> !dec_valid);

endmodule

// File: rtl/hdlc_afr_top.sv
module hdlc_afr_top
   import hdlc_afr_pkg::*;
#(
   parameter int unsigned NUM_CH   = 32,
   parameter int unsigned CMD_W    = 16,
   parameter bit          HAS_MASK = 1'b1,
   localparam int unsigned CH_W    = $clog2(NUM_CH),
   localparam int unsigned WORD_W  = 2 * OCTET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_cmd_we,
   input  logic [CMD_W-1:0]  cpu_cmd_wdata,
   input  logic              cpu_data_we,
   input  logic [WORD_W-1:0] cpu_data_wdata,
   output logic [CMD_W-1:0]  cpu_cmd_q,
   output logic [WORD_W-1:0] cpu_data_q,
   output logic              cpu_busy,
   input  logic              rx_valid,
   input  logic [CH_W-1:0]   rx_ch,
   input  logic              rx_second,
   input  logic [OCTET_W-1:0] rx_byte,
   input  logic [NUM_CH-1:0] cfg_en_first,
   input  logic [NUM_CH-1:0] cfg_en_second,
   output logic              dec_valid,
   output logic [CH_W-1:0]   dec_ch,
   output logic              dec_accept
);

   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_num_ch
      $error("hdlc_afr_top: NUM_CH must be a power of two of at least 2");
   end

   logic [CH_W-1:0]   acc_ch;
   afr_tgt_e          acc_tgt;
   logic              mem_we;
   logic [WORD_W-1:0] acc_rdata, rx_addr, rx_mask;

   afr_cpu_port #(.CH_W(CH_W), .CMD_W(CMD_W), .WORD_W(WORD_W)) i_cpu (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (cpu_cmd_we),
      .cmd_wdata  (cpu_cmd_wdata),
      .data_we    (cpu_data_we),
      .data_wdata (cpu_data_wdata),
      .rx_lookup  (rx_valid),
      .mem_rdata  (acc_rdata),
      .cmd_q      (cpu_cmd_q),
      .data_q     (cpu_data_q),
      .busy       (cpu_busy),
      .acc_ch     (acc_ch),
      .acc_tgt    (acc_tgt),
      .mem_we     (mem_we)
   );

   afr_regfile #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .HAS_MASK(HAS_MASK)) i_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (mem_we),
      .acc_tgt   (acc_tgt),
      .acc_ch    (acc_ch),
      .wr_data   (cpu_data_q),
      .acc_rdata (acc_rdata),
      .rx_ch     (rx_ch),
      .rx_addr   (rx_addr),
      .rx_mask   (rx_mask)
   );

   afr_match #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) i_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_ch      (rx_ch),
      .rx_second  (rx_second),
      .rx_byte    (rx_byte),
      .ref_word   (rx_addr),
      .dc_word    (rx_mask),
      .en_first   (cfg_en_first),
      .en_second  (cfg_en_second),
      .dec_valid  (dec_valid),
      .dec_ch     (dec_ch),
      .dec_accept (dec_accept)
   );

endmodule

// File: tb/test_hdlc_afr_top.sv
module test_hdlc_afr_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_cmd_we = 1'b0;
   logic [15:0] cpu_cmd_wdata = '0;
   logic        cpu_data_we = 1'b0;
   logic [15:0] cpu_data_wdata = '0;
   logic [15:0] cpu_cmd_q, cpu_data_q;
   logic        cpu_busy;
   logic        rx_valid = 1'b0;
   logic [4:0]  rx_ch = '0;
   logic        rx_second = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic [31:0] cfg_en_first = '0;
   logic [31:0] cfg_en_second = '0;
   logic        dec_valid;
   logic [4:0]  dec_ch;
   logic        dec_accept;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_afr_top i_hdlc_afr_top (
      .clk(clk), .rst_n(rst_n),
      .cpu_cmd_we(cpu_cmd_we), .cpu_cmd_wdata(cpu_cmd_wdata),
      .cpu_data_we(cpu_data_we), .cpu_data_wdata(cpu_data_wdata),
      .cpu_cmd_q(cpu_cmd_q), .cpu_data_q(cpu_data_q), .cpu_busy(cpu_busy),
      .rx_valid(rx_valid), .rx_ch(rx_ch), .rx_second(rx_second), .rx_byte(rx_byte),
      .cfg_en_first(cfg_en_first), .cfg_en_second(cfg_en_second),
      .dec_valid(dec_valid), .dec_ch(dec_ch), .dec_accept(dec_accept)
   );

   int n_vec = 0;
   int n_err = 0;

   // Reference model state, built from the requirements
   logic [15:0] m_addr [32];
   logic [15:0] m_mask [32];
   logic        m_first_ok [32];
   logic [15:0] m_cmd = '0, m_data = '0;
   logic        m_busy = 1'b0;
   logic        e_dv = 1'b0, e_acc = 1'b0;
   logic [4:0]  e_dch = '0;

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic oct_ok(input logic [7:0] rx, input logic [7:0] r, input logic [7:0] m);
      return ((rx ^ r) & ~m) == 8'h00;
   endfunction

   // One cycle: drive after a falling edge, model at the rising edge, compare at the next falling edge
   task automatic tick(input bit cwe, input logic [15:0] cw, input bit dwe, input logic [15:0] dw,
                       input bit rv, input logic [4:0] rc, input bit rs, input logic [7:0] rb,
                       input string tag);
      logic busy_tag_rx;
      logic exec;
      logic [4:0] ach;
      cpu_cmd_we = cwe; cpu_cmd_wdata = cw; cpu_data_we = dwe; cpu_data_wdata = dw;
      rx_valid = rv; rx_ch = rc; rx_second = rs; rx_byte = rb;
      busy_tag_rx = m_busy && rv;
      @(posedge clk);
      // decision (R5, R6, R7, R8, R9, R12)
      e_dv = 1'b0;
      if (rv) begin
         logic [7:0] r8, k8;
         logic en1, en2, h;
         r8 = rs ? m_addr[rc][15:8] : m_addr[rc][7:0];
         k8 = rs ? m_mask[rc][15:8] : m_mask[rc][7:0];
         h = oct_ok(rb, r8, k8);
         en1 = cfg_en_first[rc]; en2 = cfg_en_second[rc];
         if (!rs) begin
            if (en2) m_first_ok[rc] = !en1 || h;
            else begin e_dv = 1'b1; e_dch = rc; e_acc = !en1 || h; end
         end else if (en2) begin
            e_dv = 1'b1; e_dch = rc; e_acc = m_first_ok[rc] && h;
         end
      end
      // processor side (R2, R3, R4, R10, R11)
      exec = m_busy && !rv;
      ach = m_cmd[4:0];
      if (exec && m_cmd[5]) m_data = m_cmd[6] ? m_mask[ach] : m_addr[ach];
      else begin
         if (exec) begin
            if (m_cmd[6]) m_mask[ach] = m_data; else m_addr[ach] = m_data;
         end
         if (dwe) m_data = dw;
      end
      if (cwe && !m_busy) begin m_cmd = cw & 16'h007F; m_busy = 1'b1; end
      else if (exec) m_busy = 1'b0;
      @(negedge clk);
      chk("R2", "cmd register", cpu_cmd_q, m_cmd);
      chk("R4", "data register", cpu_data_q, m_data);
      chk(busy_tag_rx ? "R10" : "R3", "busy", cpu_busy, m_busy);
      chk(tag, "decision valid", dec_valid, e_dv);
      if (e_dv) begin
         chk(tag, "decision channel", dec_ch, e_dch);
         chk(tag, "decision accept", dec_accept, e_acc);
      end
   endtask

   task automatic idle();
      tick(0, '0, 0, '0, 0, '0, 0, '0, "R7");
   endtask

   function automatic logic [15:0] cmd_word(input logic [4:0] ch, input bit rd, input bit tgt);
      return {9'h0, tgt, rd, ch};
   endfunction

   task automatic mem_write(input logic [4:0] ch, input bit tgt, input logic [15:0] v);
      tick(0, '0, 1, v, 0, '0, 0, '0, "R4");
      tick(1, cmd_word(ch, 0, tgt), 0, '0, 0, '0, 0, '0, "R4");
      idle();
   endtask

   task automatic mem_read(input logic [4:0] ch, input bit tgt, input logic [15:0] exp, input string tag);
      tick(1, cmd_word(ch, 1, tgt), 0, '0, 0, '0, 0, '0, tag);
      idle();
      chk(tag, "readback", cpu_data_q, exp);
   endtask

   task automatic octet(input logic [4:0] ch, input bit second, input logic [7:0] b, input string tag);
      tick(0, '0, 0, '0, 1, ch, second, b, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) begin
         m_addr[i] = '0; m_mask[i] = '0; m_first_ok[i] = 1'b0;
      end
      void'($urandom(32'h1DC0_5EED));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "cmd after reset", cpu_cmd_q, 16'h0000);
      chk("R1", "data after reset", cpu_data_q, 16'h0000);
      chk("R1", "busy after reset", cpu_busy, 1'b0);
      chk("R1", "dec_valid after reset", dec_valid, 1'b0);
      rst_n = 1'b1;
      idle();
      mem_read(5'd5, 0, 16'h0000, "R1");
      mem_read(5'd31, 1, 16'h0000, "R1");

      // R3: data register write alone touches no memory word
      tick(0, '0, 1, 16'hA55A, 0, '0, 0, '0, "R3");
      idle();
      mem_read(5'd3, 0, 16'h0000, "R3");

      // R2: upper command bits are dropped
      tick(1, 16'hFF80 | cmd_word(5'd9, 1, 0), 0, '0, 0, '0, 0, '0, "R2");
      chk("R2", "cmd masked", cpu_cmd_q, 16'h0029);
      idle();

      // R4, R5: load channel 3, read both memories back
      mem_write(5'd3, 0, 16'h12C4);
      mem_write(5'd3, 1, 16'h0F00);
      mem_read(5'd3, 0, 16'h12C4, "R4");
      mem_read(5'd3, 1, 16'h0F00, "R4");

      // R6, R5: both enables, masked low nibble of the second octet
      cfg_en_first[3] = 1'b1; cfg_en_second[3] = 1'b1;
      octet(5'd3, 0, 8'hC4, "R12");
      octet(5'd3, 1, 8'h1F, "R6");
      chk("R6", "masked bits ignored", {dec_valid, dec_accept}, 2'b11);
      // R9: mismatch in compared bit of second octet
      octet(5'd3, 0, 8'hC4, "R9");
      octet(5'd3, 1, 8'h2F, "R9");
      chk("R9", "second octet mismatch", {dec_valid, dec_accept}, 2'b10);
      // R9: mismatch in first octet carried to the decision
      octet(5'd3, 0, 8'hC5, "R9");
      octet(5'd3, 1, 8'h12, "R9");
      chk("R9", "first octet mismatch", {dec_valid, dec_accept}, 2'b10);

      // R7, R12: first enable only
      cfg_en_second[3] = 1'b0;
      octet(5'd3, 0, 8'hC4, "R7");
      chk("R7", "decision after first octet", {dec_valid, dec_accept}, 2'b11);
      octet(5'd3, 1, 8'hEE, "R12");
      chk("R12", "no pulse on unused second", dec_valid, 1'b0);

      // R7: second enable only, first octet not compared
      cfg_en_first[3] = 1'b0; cfg_en_second[3] = 1'b1;
      octet(5'd3, 0, 8'h00, "R12");
      octet(5'd3, 1, 8'h13, "R7");
      chk("R7", "second only accept", {dec_valid, dec_ch, dec_accept}, {1'b1, 5'd3, 1'b1});

      // R8: no enables
      cfg_en_second[3] = 1'b0;
      octet(5'd3, 0, 8'h77, "R8");
      chk("R8", "open channel accept", {dec_valid, dec_accept}, 2'b11);

      // R10, R11: receive traffic holds a read; second command dropped
      tick(1, cmd_word(5'd3, 1, 0), 0, '0, 0, '0, 0, '0, "R10");
      tick(1, cmd_word(5'd7, 0, 1), 0, '0, 1, 5'd3, 0, 8'h00, "R10");
      chk("R11", "cmd kept while busy", cpu_cmd_q, 16'h0023);
      octet(5'd3, 0, 8'h00, "R10");
      chk("R10", "busy held by receive", cpu_busy, 1'b1);
      idle();
      chk("R10", "deferred read", cpu_data_q, 16'h12C4);
      mem_read(5'd7, 1, 16'h0000, "R11");

      // Constrained random traffic on a few channels
      for (int it = 0; it < 4000; it++) begin
         logic [4:0] ch, cch;
         logic [7:0] b;
         bit s, pick;
         if (it % 200 == 0) begin
            for (int c = 0; c < 32; c++) begin
               cfg_en_first[c]  = $urandom % 2;
               cfg_en_second[c] = $urandom % 2;
            end
         end
         ch  = ($urandom % 5 == 4) ? 5'd31 : 5'($urandom % 4);
         cch = ($urandom % 5 == 4) ? 5'd31 : 5'($urandom % 4);
         s   = $urandom % 2;
         pick = $urandom % 2;
         b = s ? m_addr[ch][15:8] : m_addr[ch][7:0];
         if (pick) b = b ^ (8'($urandom) & (s ? m_mask[ch][15:8] : m_mask[ch][7:0]));
         else b = 8'($urandom);
         tick($urandom % 6 == 0, {7'($urandom), 2'($urandom), cch}, $urandom % 4 == 0, 16'($urandom),
              $urandom % 2 == 1, ch, s, b, "R9");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

endmodule